// File: doc/BRIEF.md
# Serial Synthesizer Register Loader

This block is the programming front end for the digital section of a fractional-N frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a latch strobe. Each rising edge of the serial clock shifts one data bit into a 24-bit word register, with the most significant bit first. A rising edge on the latch strobe then copies the word into one of four destination registers. The two lowest bits of the word select the destination.

All three wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer with edge detection. The block provides the integer and fractional divide values, the reference divide value, the active modulus, and the full words last written to the control and noise/spur destinations. It also raises a one-cycle load pulse for each destination.

The modulus is double buffered. Writing the reference word changes the reference divide value at once, but it only stages the modulus. The staged modulus becomes active on the next write to the divider word.

Top module: `synth_prog_loader`

## Requirements
- R1: After the active-low reset, every value output and every load pulse output is zero.
- R2: Each rising edge of the serial clock shifts the word register left by one bit and puts the sampled data bit in bit 0, so a 24-bit word is sent most significant bit first.
- R3: A latch rising edge sends the word by its bits 1:0. Code 0 goes to the divider word, code 1 to the reference word, code 2 to the control word and code 3 to the noise/spur word. The control and noise/spur outputs show all 24 bits as written.
- R4: A divider-word load sets the integer value from bits 22:14 and the fractional value from bits 13:2.
- R5: A reference-word load sets the reference divide value from bits 17:14 at once. It stages the modulus from bits 13:2 and leaves the active modulus unchanged.
- R6: A divider-word load copies the staged modulus to the active modulus. Repeated reference-word loads with no divider-word load between them never change the active modulus.
- R7: Each latch rising edge gives exactly one single-cycle pulse on the load output of the selected destination and none on the other three. The pulse is high in the first cycle in which the new value shows on the outputs.
- R8: A load changes only the registers of its own destination. Every other output holds its value.
- R9: Bit 23 of a divider word and bits 23:18 of a reference word are ignored.
- R10: A latch edge after fewer than 24 serial clock edges still transfers the word register as it stands. The register is not cleared by a load, so older bits stay in the upper positions.
- R11: Holding the serial clock high shifts only once, and holding the latch strobe high loads only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, sampled on the serClk rising edge |
| latchEn | input | 1 | Latch strobe, acts on its rising edge |
| intDiv | output | 9 | Integer divide value |
| fracVal | output | 12 | Fractional value |
| refDiv | output | 4 | Reference divide value |
| modActive | output | 12 | Active modulus |
| ctrlWord | output | 24 | Last control word |
| noiseWord | output | 24 | Last noise/spur word |
| loadDivPulse | output | 1 | Divider word loaded |
| loadRefPulse | output | 1 | Reference word loaded |
| loadCtrlPulse | output | 1 | Control word loaded |
| loadNoisePulse | output | 1 | Noise/spur word loaded |

## Verification
The bench targets the double-buffer order. It sends reference words in runs with no divider word between them and checks that the active modulus stays fixed. A design that copied the modulus straight through would change the modulus on the reference write. Other cases are short words, reserved upper bits set to one, and strobes held high for many cycles. These catch a design that clears or counts bits, leaks reserved bits into a field, or acts on levels instead of edges, which would show up as extra shifts, extra pulses or corrupted fields. Random words to all four destinations catch decode errors that would write or pulse the wrong destination.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [1:0] {
    DEST_DIV   = 2'd0,
    DEST_REF   = 2'd1,
    DEST_CTRL  = 2'd2,
    DEST_NOISE = 2'd3
  } destSel_t;

  typedef struct packed {
    logic shiftEn;
    logic dataBit;
    logic loadDiv;
    logic loadRef;
    logic loadCtrl;
    logic loadNoise;
  } progStrb_t;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '0;
      prevLevel <= 1'b0;
    end else begin
      chain     <= {chain[STAGES-2:0], asyncIn};
      prevLevel <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prevLevel;

  p_single_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              latchEn,
  input  logic [ADDR_W-1:0] addrBits,
  output progStrb_t         strb
);
  localparam int N_LINES = 3;
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LE  = 2;

  logic [N_LINES-1:0] rawPins;
  logic [N_LINES-1:0] lineLvl;
  logic [N_LINES-1:0] lineRise;

  assign rawPins = {latchEn, serData, serClk};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    sp_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(rawPins[g]),
      .level  (lineLvl[g]),
      .rise   (lineRise[g])
    );
  end

  destSel_t dest;
  assign dest = destSel_t'(addrBits[1:0]);

  always_comb begin
    strb           = '0;
    strb.shiftEn   = lineRise[IDX_CLK];
    strb.dataBit   = lineLvl[IDX_DAT];
    if (lineRise[IDX_LE]) begin
      unique case (dest)
        DEST_DIV:   strb.loadDiv   = 1'b1;
        DEST_REF:   strb.loadRef   = 1'b1;
        DEST_CTRL:  strb.loadCtrl  = 1'b1;
        DEST_NOISE: strb.loadNoise = 1'b1;
        default:    strb.loadDiv   = 1'b0;
      endcase
    end
  end

  p_one_dest_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadDiv, strb.loadRef, strb.loadCtrl, strb.loadNoise}));
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import synth_prog_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2,
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12,
  parameter int REF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  progStrb_t         strb,
  output logic [ADDR_W-1:0] addrBits,
  output logic [INT_W-1:0]  intDiv,
  output logic [FRAC_W-1:0] fracVal,
  output logic [REF_W-1:0]  refDiv,
  output logic [FRAC_W-1:0] modActive,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] noiseWord,
  output logic              loadDivPulse,
  output logic              loadRefPulse,
  output logic              loadCtrlPulse,
  output logic              loadNoisePulse
);
  localparam int FRAC_LSB = ADDR_W;
  localparam int FRAC_MSB = FRAC_LSB + FRAC_W - 1;
  localparam int HI_LSB   = FRAC_MSB + 1;
  localparam int INT_MSB  = HI_LSB + INT_W - 1;
  localparam int REF_MSB  = HI_LSB + REF_W - 1;

  logic [WORD_W-1:0] shiftReg;
  logic [FRAC_W-1:0] modStaged;

  assign addrBits = shiftReg[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strb.dataBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intDiv    <= '0;
      fracVal   <= '0;
      refDiv    <= '0;
      modStaged <= '0;
      modActive <= '0;
      ctrlWord  <= '0;
      noiseWord <= '0;
    end else begin
      if (strb.loadDiv) begin
        intDiv    <= shiftReg[INT_MSB:HI_LSB];
        fracVal   <= shiftReg[FRAC_MSB:FRAC_LSB];
        modActive <= modStaged;
      end
      if (strb.loadRef) begin
        refDiv    <= shiftReg[REF_MSB:HI_LSB];
        modStaged <= shiftReg[FRAC_MSB:FRAC_LSB];
      end
      if (strb.loadCtrl)  ctrlWord  <= shiftReg;
      if (strb.loadNoise) noiseWord <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadDivPulse   <= 1'b0;
      loadRefPulse   <= 1'b0;
      loadCtrlPulse  <= 1'b0;
      loadNoisePulse <= 1'b0;
    end else begin
      loadDivPulse   <= strb.loadDiv;
      loadRefPulse   <= strb.loadRef;
      loadCtrlPulse  <= strb.loadCtrl;
      loadNoisePulse <= strb.loadNoise;
    end
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> shiftReg[0] == $past(strb.dataBit));
  p_mod_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDiv |=> $stable(modActive));
  p_mod_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDiv |=> modActive == $past(modStaged));
  p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRef |=> $stable(refDiv) && $stable(modStaged));
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadDivPulse |=> !loadDivPulse);
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int ADDR_W      = 2,
  parameter int INT_W       = 9,
  parameter int FRAC_W      = 12,
  parameter int REF_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              latchEn,
  output logic [INT_W-1:0]  intDiv,
  output logic [FRAC_W-1:0] fracVal,
  output logic [REF_W-1:0]  refDiv,
  output logic [FRAC_W-1:0] modActive,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] noiseWord,
  output logic              loadDivPulse,
  output logic              loadRefPulse,
  output logic              loadCtrlPulse,
  output logic              loadNoisePulse
);
  progStrb_t         strb;
  logic [ADDR_W-1:0] addrBits;

  sp_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .latchEn(latchEn), .addrBits(addrBits), .strb(strb)
  );

  sp_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .INT_W(INT_W),
                .FRAC_W(FRAC_W), .REF_W(REF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrBits(addrBits),
    .intDiv(intDiv), .fracVal(fracVal), .refDiv(refDiv),
    .modActive(modActive), .ctrlWord(ctrlWord), .noiseWord(noiseWord),
    .loadDivPulse(loadDivPulse), .loadRefPulse(loadRefPulse),
    .loadCtrlPulse(loadCtrlPulse), .loadNoisePulse(loadNoisePulse)
  );
endmodule

// File: tb/synth_prog_loader_tb.sv
module synth_prog_loader_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, latchEn = 1'b0;
  logic [8:0]  intDiv;
  logic [11:0] fracVal, modActive;
  logic [3:0]  refDiv;
  logic [23:0] ctrlWord, noiseWord;
  logic pDiv, pRef, pCtrl, pNoise;

  always #2.5 clk = ~clk;

  synth_prog_loader dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .latchEn(latchEn), .intDiv(intDiv), .fracVal(fracVal), .refDiv(refDiv),
    .modActive(modActive), .ctrlWord(ctrlWord), .noiseWord(noiseWord),
    .loadDivPulse(pDiv), .loadRefPulse(pRef), .loadCtrlPulse(pCtrl),
    .loadNoisePulse(pNoise)
  );

  int nChecks = 0, nFails = 0;
  int cntDiv = 0, cntRef = 0, cntCtrl = 0, cntNoise = 0;
  bit watchdogHit = 0;
  bit done = 0;

  // model state
  logic [23:0] mShift = '0;
  logic [8:0]  mInt = '0;
  logic [11:0] mFrac = '0, mStaged = '0, mMod = '0;
  logic [3:0]  mRef = '0;
  logic [23:0] mCtrl = '0, mNoise = '0;

  always @(negedge clk) begin
    if (pDiv)   cntDiv++;
    if (pRef)   cntRef++;
    if (pCtrl)  cntCtrl++;
    if (pNoise) cntNoise++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int hold);
    serData = b; waitClk(4);
    serClk = 1'b1; waitClk(hold);
    serClk = 1'b0; waitClk(4);
    mShift = {mShift[22:0], b};
  endtask

  function automatic void modelLoad();
    case (mShift[1:0])
      2'd0: begin mInt = mShift[22:14]; mFrac = mShift[13:2]; mMod = mStaged; end
      2'd1: begin mRef = mShift[17:14]; mStaged = mShift[13:2]; end
      2'd2: mCtrl = mShift;
      default: mNoise = mShift;
    endcase
  endfunction

  task automatic latch(input int hold, input string tag);
    int d0, r0, c0, n0;
    logic [1:0] dst;
    d0 = cntDiv; r0 = cntRef; c0 = cntCtrl; n0 = cntNoise;
    dst = mShift[1:0];
    latchEn = 1'b1; waitClk(hold);
    latchEn = 1'b0; waitClk(6);
    modelLoad();
    chk({tag, " R4 intDiv"}, intDiv, mInt);
    chk({tag, " R4 fracVal"}, fracVal, mFrac);
    chk({tag, " R5 refDiv"}, refDiv, mRef);
    chk({tag, " R6 modActive"}, modActive, mMod);
    chk({tag, " R3 ctrlWord"}, ctrlWord, mCtrl);
    chk({tag, " R3 noiseWord"}, noiseWord, mNoise);
    chk({tag, " R7 div pulses"}, cntDiv - d0, (dst == 2'd0) ? 1 : 0);
    chk({tag, " R7 ref pulses"}, cntRef - r0, (dst == 2'd1) ? 1 : 0);
    chk({tag, " R7 ctrl pulses"}, cntCtrl - c0, (dst == 2'd2) ? 1 : 0);
    chk({tag, " R7 noise pulses"}, cntNoise - n0, (dst == 2'd3) ? 1 : 0);
  endtask

  task automatic writeWord(input logic [23:0] w, input string tag);
    for (int i = 23; i >= 0; i--) sendBit(w[i], 4);
    latch(4, tag);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5EED1234);
    waitClk(5);
    chk("R1 intDiv", intDiv, 0);
    chk("R1 fracVal", fracVal, 0);
    chk("R1 refDiv", refDiv, 0);
    chk("R1 modActive", modActive, 0);
    chk("R1 ctrlWord", ctrlWord, 0);
    chk("R1 noiseWord", noiseWord, 0);
    chk("R1 pulses", {pDiv, pRef, pCtrl, pNoise}, 0);
    rstN = 1'b1;
    waitClk(4);

    // R2/R3: MSB-first control and noise words
    writeWord(24'hA5C3_5A | 24'h2, "R2 ctrl");
    writeWord(24'h3C_96F3, "R3 noise");
    // R5: reference write stages modulus only
    writeWord({6'h3F, 4'h9, 12'hABC, 2'b01}, "R5 ref, R9 reserved");
    writeWord({6'h00, 4'h3, 12'h123, 2'b01}, "R5 ref again");
    chk("R6 mod still zero", modActive, 0);
    // R6: divider write activates the staged modulus
    writeWord({1'b1, 9'h1A5, 12'h777, 2'b00}, "R6 div, R9 bit23");
    chk("R6 mod active", modActive, 12'h123);
    // R11: long strobes
    for (int i = 23; i >= 2; i--) sendBit(i[0], (i == 10) ? 30 : 4);
    sendBit(1'b1, 25); sendBit(1'b0, 4);
    latch(40, "R11 long strobes");
    // R10: short word of 5 bits then latch
    for (int i = 0; i < 5; i++) sendBit((i == 3) ? 1'b1 : i[0], 4);
    latch(4, "R10 short word");
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [23:0] w;
      w = $urandom();
      if (k % 5 == 4) w[1:0] = 2'b01;
      writeWord(w, "R8 random");
    end
    writeWord(24'h00_0004, "R6 final div");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(negedge clk);
    if (!done) begin
      watchdogHit = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule